// File: doc/BRIEF.md
# Programmable Saturating BCD Counter

The block counts upward from zero to a limit chosen by the user and then stays at that value. The count is shown as two binary-coded decimal digits, one for tens and one for ones. The count range is 0 to 99. A 7-bit binary limit can carry values up to 127, so any limit above 99 is clamped to 99.

A single control pin picks the mode. While the control is low the block is in set mode. The count is held at zero, and the limit input is sampled into a holding register on every clock. While the control is high the block is in run mode. The held limit is frozen, and the count steps up by one on each cycle where the enable tick is high. When the count equals the held limit it stops there. The enable tick lets the surrounding logic pick a visible counting rate that is much slower than the 100 MHz core clock.

The block has no data stream, so there is no handshake and no back-pressure. Every pin is a plain level or pulse that is sampled on the rising clock edge. Both digits are driven combinationally from the count register, so they change in the cycle right after the edge that updates the count.

Top module: `bcd_sat_counter`

## Requirements
- R1: A synchronous active-high reset clears both the count and the held limit. If run is high when reset is released, the digits stay at 0 whatever ticks arrive.
- R2: On every edge where run is low, the count becomes 0 and does not advance, even when tick is high.
- R3: While run is high, the count rises by exactly one at each edge where tick is high and the count is below the held limit. At an edge where tick is low, the count is unchanged.
- R4: Once the count equals the held limit in run mode, it holds that value on every later tick until run goes low.
- R5: A limit input above 99 is held as 99, so the count never goes above 99.
- R6: Changes on the limit input while run is high have no effect on the sequence in progress.
- R7: With a held limit of 0, the digits remain 0 after run is asserted.
- R8: The tens output equals count/10 and the ones output equals count mod 10. Each is a 4-bit value from 0 to 9.
- R9: The held limit is the value present at the last edge in set mode before run rises. Earlier values seen in set mode have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| tick_i | input | 1 | Count-enable pulse |
| run_i | input | 1 | 0 = set mode, 1 = run mode |
| limit_i | input | 7 | Binary count limit |
| tens_o | output | 4 | BCD tens digit |
| ones_o | output | 4 | BCD ones digit |

## Verification
The embedded properties check the following on every cycle:
- the held limit never exceeds 99;
- the limit is frozen in run mode;
- the count is zero after any set-mode edge;
- the count never passes the held limit;
- the count is stable on run cycles without a tick;
- the two digits always recombine to the binary count.

Other behaviours can only be shown by the bench's scenarios:
- which limit value is captured at the set-to-run boundary;
- saturation at exactly the clamped limit for every one of the 128 limit codes;
- the reset state of the held limit.

// File: rtl/bcdcnt_pkg.sv
package bcdcnt_pkg;
  localparam int MAX_VAL    = 99;
  localparam int LIM_W      = 7;
  localparam int CNT_W      = $clog2(MAX_VAL + 1);
  localparam int NUM_DIGITS = 2;
  typedef logic [3:0] bcd_t;
endpackage

// File: rtl/bcdcnt_limit.sv
module bcdcnt_limit
  import bcdcnt_pkg::*;
#(
  parameter int LW   = LIM_W,
  parameter int CW   = CNT_W,
  parameter int MAXV = MAX_VAL
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run_i,
  input  logic [LW-1:0] limit_i,
  output logic [CW-1:0] limit_q
);
  localparam logic [LW-1:0] MAX_IN  = LW'(MAXV);
  localparam logic [CW-1:0] MAX_CNT = CW'(MAXV);

  logic [CW-1:0] clamped;

  always_comb begin
    if (limit_i > MAX_IN) clamped = MAX_CNT;
    else                  clamped = CW'(limit_i);
  end

  always_ff @(posedge clk) begin
    if (rst)         limit_q <= '0;
    else if (!run_i) limit_q <= clamped;
  end

  assert_limit_clamped_R5: assert property (@(posedge clk) disable iff (rst)
    limit_q <= MAX_CNT);

  assert_limit_frozen_R6: assert property (@(posedge clk) disable iff (rst)
    run_i |=> $stable(limit_q));
endmodule

// File: rtl/bcdcnt_core.sv
module bcdcnt_core
  import bcdcnt_pkg::*;
#(
  parameter int CW = CNT_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run_i,
  input  logic          tick_i,
  input  logic [CW-1:0] limit_q,
  output logic [CW-1:0] count_q
);
  logic below;
  assign below = (count_q < limit_q);

  always_ff @(posedge clk) begin
    if (rst)                         count_q <= '0;
    else if (!run_i)                 count_q <= '0;
    else if (tick_i && below)        count_q <= CW'(count_q + 1'b1);
  end

  assert_set_zero_R2: assert property (@(posedge clk) disable iff (rst)
    !run_i |=> (count_q == '0));

  assert_no_tick_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (run_i && !tick_i) |=> $stable(count_q));

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (rst)
    count_q <= limit_q);
endmodule

// File: rtl/bcdcnt_bcd.sv
module bcdcnt_bcd
  import bcdcnt_pkg::*;
#(
  parameter int CW = CNT_W,
  parameter int ND = NUM_DIGITS
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [CW-1:0]       bin_i,
  output logic [ND-1:0][3:0]  digits_o
);
  function automatic int pow10(input int n);
    int p;
    p = 1;
    for (int k = 0; k < n; k++) p = p * 10;
    return p;
  endfunction

  for (genvar g = 0; g < ND; g++) begin : g_digit
    localparam int WEIGHT = pow10(g);
    assign digits_o[g] = 4'((int'(bin_i) / WEIGHT) % 10);
  end

  int recon;
  always_comb begin
    recon = 0;
    for (int k = 0; k < ND; k++) recon = recon + int'(digits_o[k]) * pow10(k);
  end

  assert_bcd_recombine_R8: assert property (@(posedge clk) disable iff (rst)
    recon == int'(bin_i));
endmodule

// File: rtl/bcd_sat_counter.sv
module bcd_sat_counter
  import bcdcnt_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             run_i,
  input  logic [LIM_W-1:0] limit_i,
  output logic [3:0]       tens_o,
  output logic [3:0]       ones_o
);
  logic [CNT_W-1:0]            limit_q;
  logic [CNT_W-1:0]            count_q;
  logic [NUM_DIGITS-1:0][3:0]  digits;

  bcdcnt_limit #(.LW(LIM_W), .CW(CNT_W), .MAXV(MAX_VAL)) u_limit (
    .clk(clk), .rst(rst), .run_i(run_i), .limit_i(limit_i), .limit_q(limit_q)
  );

  bcdcnt_core #(.CW(CNT_W)) u_core (
    .clk(clk), .rst(rst), .run_i(run_i), .tick_i(tick_i),
    .limit_q(limit_q), .count_q(count_q)
  );

  bcdcnt_bcd #(.CW(CNT_W), .ND(NUM_DIGITS)) u_bcd (
    .clk(clk), .rst(rst), .bin_i(count_q), .digits_o(digits)
  );

  assign ones_o = digits[0];
  assign tens_o = digits[1];
endmodule

// File: tb/sim_bcd_sat_counter.sv
module sim_bcd_sat_counter;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_i = 1'b0;
  logic       run_i = 1'b0;
  logic [6:0] limit_i = '0;
  logic [3:0] tens_o, ones_o;

  int checks = 0;
  int errors = 0;
  int exp_cnt = 0;
  int exp_lim = 0;
  bit done = 0;

  always #2 clk = ~clk;

  bcd_sat_counter u0 (
    .clk(clk), .rst(rst), .tick_i(tick_i), .run_i(run_i),
    .limit_i(limit_i), .tens_o(tens_o), .ones_o(ones_o)
  );

  task automatic check(input string tag, input int act, input int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic check_digits(input string tag);
    check({tag, " tens"}, int'(tens_o), exp_cnt / 10);
    check({tag, " ones"}, int'(ones_o), exp_cnt % 10);
  endtask

  // One clock: drive on the falling edge, update the spec model at the rising edge, sample 1 ns later.
  task automatic step(input logic t, input logic r, input logic [6:0] l, input string tag);
    @(negedge clk);
    tick_i = t; run_i = r; limit_i = l;
    @(posedge clk);
    if (rst) begin exp_cnt = 0; exp_lim = 0; end
    else if (!r) begin exp_cnt = 0; exp_lim = (int'(l) > 99) ? 99 : int'(l); end
    else if (t && exp_cnt < exp_lim) exp_cnt++;
    #1;
    check_digits(tag);
  endtask

  initial begin
    // R1: reset with run held high, so no limit can be captured
    run_i = 1'b1; limit_i = 7'd55;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset tens", int'(tens_o), 0);
    check("R1 reset ones", int'(ones_o), 0);
    @(negedge clk); rst = 1'b0;
    for (int k = 0; k < 10; k++) step(1'b1, 1'b1, 7'd55, "R1 held limit zero");

    // Exhaustive sweep over all 128 limit codes
    for (int lim = 0; lim < 128; lim++) begin
      string tg;
      for (int k = 0; k < 3; k++) step(1'b1, 1'b0, 7'(lim), "R2 set mode zero");
      tg = (lim == 0) ? "R7 zero limit" : (lim > 99) ? "R5 clamp" : "R3 count";
      for (int k = 0; k < 160; k++) begin
        // R6: limit input is scrambled throughout run
        step(k % 3 != 2, 1'b1, 7'(~lim + k), tg);
      end
      check((lim > 99) ? "R5 final" : "R4 hold at limit", exp_cnt, (lim > 99) ? 99 : lim);
      check("R4 final tens", int'(tens_o), ((lim > 99) ? 99 : lim) / 10);
      check("R8 digit range", int'(tens_o <= 4'd9 && ones_o <= 4'd9), 1);
    end

    // R9: only the last set-mode limit counts
    step(1'b0, 1'b0, 7'd50, "R9 set");
    step(1'b0, 1'b0, 7'd80, "R9 set");
    step(1'b0, 1'b0, 7'd23, "R9 set");
    for (int k = 0; k < 40; k++) step(1'b1, 1'b1, 7'd90, "R9 run");
    check("R9 captured limit tens", int'(tens_o), 2);
    check("R9 captured limit ones", int'(ones_o), 3);

    // R2: falling back to set mode mid-count clears the count
    step(1'b0, 1'b0, 7'd99, "R2 set");
    for (int k = 0; k < 12; k++) step(1'b1, 1'b1, 7'd0, "R3 partial");
    step(1'b1, 1'b0, 7'd99, "R2 abort to zero");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule